// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block keeps time from a 32.768 kHz slow clock. A 47-bit counter advances once per slow-clock period; its upper 32 bits (bits 46:15) are a seconds count and its lower 15 bits count ticks within the second. Software reaches the block over a simple 32-bit register bus running on the fast system clock. It can stop the counter, preload it, start it again, program a seconds alarm, and clear a sticky alarm flag that drives an interrupt pin and a wakeup pin.

The slow clock enters as a plain input. Two flops synchronise it, and its rising edge is turned into a one-cycle tick in the fast domain. All writes that affect timekeeping are held in staging registers. They take effect on the next tick, so the run state that software reads back follows that tick and not the write. The bus has no back-pressure. The block accepts a read or a write in every cycle, and read data is always ready one cycle after the read strobe.

Top module: `slow_rtc`

## Requirements
- R1: The counter is 47 bits wide. It advances by one on every tick while the applied run bit is 1, wraps from all ones to zero, and does not change between ticks.
- R2: A read of offset 0x20 returns counter bits 31:0. A read of offset 0x1C returns counter bits 46:32 in bits 14:0, with zeros above. The seconds value is counter bits 46:15.
- R3: The control register is at offset 0x04, with bit 0 = run, bit 1 = alarm enable and bit 3 = wakeup enable. A write to it takes effect on the first tick after the write, and until then bit 0 reads back the old run state.
- R4: A write to offset 0x20 or 0x1C is staged and loaded into that half of the counter on the next tick, but only if the applied run bit is 0 at that tick. Otherwise the staged value is discarded.
- R5: The alarm register is at offset 0x24 and holds 32 bits of seconds. A write is applied on the next tick, and reads return the applied value.
- R6: Status bit 0 at offset 0x18 is set on a tick where the applied alarm enable is 1 and the seconds value equals the applied alarm. It stays set until a 1 is written to that bit. Writing 0 has no effect, and a set in the same cycle as a clear wins.
- R7: irq equals the status flag AND the applied alarm enable. wake equals the status flag AND the applied wakeup enable.
- R8: The guard register at offset 0x30 stores any 32-bit value written to it, for example 0x41736166, and returns that value on reads.
- R9: After reset, every register reads 0 and irq and wake are 0. Reads of unmapped offsets return 0.
- R10: bus_rdata holds the addressed value from the cycle after the read strobe onward.
- R11: The tick occurs at the second fast clock edge after slow_clk rises, and exactly one tick occurs per slow-clock rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_clk | input | 1 | 32.768 kHz slow clock, asynchronous to clk |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| irq | output | 1 | Alarm interrupt |
| wake | output | 1 | Wakeup request |

## Verification
A staged write is applied on the third fast edge after slow_clk rises: two edges go to synchronisation and the third acts on the tick. The bench's slow-clock task holds slow_clk high for two fast cycles and low for two more, so every effect of a tick has happened by the time the task returns. Read data is sampled on the falling edge one cycle after the strobe. irq and wake are sampled after the bus write or the slow pulse that changes them, never in the same cycle. Each check is placed where the requirements predict the count value, including the increment that is still applied at the tick that stops the counter.

// File: rtl/slow_rtc_pkg.sv
package slow_rtc_pkg;
  localparam logic [7:0] OFS_CTRL   = 8'h04;
  localparam logic [7:0] OFS_FLAGS  = 8'h18;
  localparam logic [7:0] OFS_CNT_HI = 8'h1C;
  localparam logic [7:0] OFS_CNT_LO = 8'h20;
  localparam logic [7:0] OFS_ALARM  = 8'h24;
  localparam logic [7:0] OFS_GUARD  = 8'h30;

  localparam int CB_RUN  = 0;
  localparam int CB_ALM  = 1;
  localparam int CB_WAKE = 3;

  typedef struct packed {
    logic wake_en;
    logic alm_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/slow_rtc_tick.sv
module slow_rtc_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_clk,
  output logic tick
);
  logic [SYNC_STAGES:0] shr;

  always_ff @(posedge clk) begin
    if (!rst_n) shr <= '0;
    else        shr <= {shr[SYNC_STAGES-1:0], slow_clk};
  end

  assign tick = shr[SYNC_STAGES-1] & ~shr[SYNC_STAGES];
endmodule

// File: rtl/slow_rtc_count.sv
module slow_rtc_count #(
  parameter int CNT_W = 47,
  parameter int LO_W  = 32,
  localparam int HI_W = CNT_W - LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             ld_lo,
  input  logic             ld_hi,
  input  logic [LO_W-1:0]  lo_val,
  input  logic [HI_W-1:0]  hi_val,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick) begin
      if (ld_lo || ld_hi) begin
        if (ld_lo) cnt[LO_W-1:0]     <= lo_val;
        if (ld_hi) cnt[CNT_W-1:LO_W] <= hi_val;
      end else if (run) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/slow_rtc_alarm.sv
module slow_rtc_alarm #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             arm,
  input  logic [SEC_W-1:0] secs,
  input  logic [SEC_W-1:0] target,
  input  logic             clr,
  output logic             flag
);
  logic hit;
  assign hit = tick && arm && (secs == target);

  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/slow_rtc.sv
module slow_rtc
  import slow_rtc_pkg::*;
#(
  parameter int SUB_W       = 15,
  parameter int SEC_W       = 32,
  parameter int DW          = 32,
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_clk,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          wake
);
  localparam int CNT_W = SUB_W + SEC_W;
  localparam int HI_W  = CNT_W - DW;

  logic tick;
  logic [CNT_W-1:0] cnt;
  logic flag;

  ctrl_t ctrl_stage, ctrl_q;
  logic  ctrl_pend;
  logic [SEC_W-1:0] alarm_stage, alarm_q;
  logic             alarm_pend;
  logic [DW-1:0]    lo_stage;
  logic [HI_W-1:0]  hi_stage;
  logic             lo_pend, hi_pend;
  logic [DW-1:0]    guard_q;
  logic [DW-1:0]    rd_mux;

  logic wr_ctrl, wr_flags, wr_hi, wr_lo, wr_alarm, wr_guard;
  assign wr_ctrl  = bus_wr && (bus_addr == AW'(OFS_CTRL));
  assign wr_flags = bus_wr && (bus_addr == AW'(OFS_FLAGS));
  assign wr_hi    = bus_wr && (bus_addr == AW'(OFS_CNT_HI));
  assign wr_lo    = bus_wr && (bus_addr == AW'(OFS_CNT_LO));
  assign wr_alarm = bus_wr && (bus_addr == AW'(OFS_ALARM));
  assign wr_guard = bus_wr && (bus_addr == AW'(OFS_GUARD));

  slow_rtc_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .tick(tick)
  );

  // Staging side: bus writes land here, ticks consume them.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_stage  <= '0;
      ctrl_pend   <= 1'b0;
      ctrl_q      <= '0;
      alarm_stage <= '0;
      alarm_pend  <= 1'b0;
      alarm_q     <= '0;
      lo_stage    <= '0;
      hi_stage    <= '0;
      lo_pend     <= 1'b0;
      hi_pend     <= 1'b0;
      guard_q     <= '0;
    end else begin
      if (tick && ctrl_pend)  ctrl_q  <= ctrl_stage;
      if (tick && alarm_pend) alarm_q <= alarm_stage;

      if (wr_ctrl) begin
        ctrl_stage.run     <= bus_wdata[CB_RUN];
        ctrl_stage.alm_en  <= bus_wdata[CB_ALM];
        ctrl_stage.wake_en <= bus_wdata[CB_WAKE];
        ctrl_pend          <= 1'b1;
      end else if (tick) begin
        ctrl_pend <= 1'b0;
      end

      if (wr_alarm) begin
        alarm_stage <= bus_wdata[SEC_W-1:0];
        alarm_pend  <= 1'b1;
      end else if (tick) begin
        alarm_pend <= 1'b0;
      end

      if (wr_lo) begin
        lo_stage <= bus_wdata;
        lo_pend  <= 1'b1;
      end else if (tick) begin
        lo_pend <= 1'b0;
      end

      if (wr_hi) begin
        hi_stage <= bus_wdata[HI_W-1:0];
        hi_pend  <= 1'b1;
      end else if (tick) begin
        hi_pend <= 1'b0;
      end

      if (wr_guard) guard_q <= bus_wdata;
    end
  end

  slow_rtc_count #(.CNT_W(CNT_W), .LO_W(DW)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctrl_q.run),
    .ld_lo(lo_pend && !ctrl_q.run), .ld_hi(hi_pend && !ctrl_q.run),
    .lo_val(lo_stage), .hi_val(hi_stage), .cnt(cnt)
  );

  slow_rtc_alarm #(.SEC_W(SEC_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(ctrl_q.alm_en),
    .secs(cnt[CNT_W-1:SUB_W]), .target(alarm_q),
    .clr(wr_flags && bus_wdata[0]), .flag(flag)
  );

  assign irq  = flag && ctrl_q.alm_en;
  assign wake = flag && ctrl_q.wake_en;

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AW'(OFS_CTRL): begin
        rd_mux[CB_RUN]  = ctrl_q.run;
        rd_mux[CB_ALM]  = ctrl_q.alm_en;
        rd_mux[CB_WAKE] = ctrl_q.wake_en;
      end
      AW'(OFS_FLAGS):  rd_mux[0] = flag;
      AW'(OFS_CNT_HI): rd_mux[HI_W-1:0] = cnt[CNT_W-1:DW];
      AW'(OFS_CNT_LO): rd_mux = cnt[DW-1:0];
      AW'(OFS_ALARM):  rd_mux[SEC_W-1:0] = alarm_q;
      AW'(OFS_GUARD):  rd_mux = guard_q;
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/slow_rtc_chk.sv
module slow_rtc_chk #(
  parameter int CNT_W = 47,
  parameter int SUB_W = 15,
  parameter int SEC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             run,
  input logic             alm_en,
  input logic [CNT_W-1:0] cnt,
  input logic [SEC_W-1:0] alarm,
  input logic             flag,
  input logic             irq
);
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_run_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(run));

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && alm_en && (cnt[CNT_W-1:SUB_W] == alarm)) |=> flag);

  assert_flag_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick));

  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
endmodule

bind slow_rtc slow_rtc_chk #(.CNT_W(CNT_W), .SUB_W(SUB_W), .SEC_W(SEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctrl_q.run),
  .alm_en(ctrl_q.alm_en), .cnt(cnt), .alarm(alarm_q), .flag(flag), .irq(irq)
);

// File: tb/sim_slow_rtc.sv
`timescale 1ns/1ps
module sim_slow_rtc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_clk = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, wake;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  slow_rtc u0 (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .wake(wake)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse();
    @(negedge clk);
    slow_clk = 1'b1;
    repeat (2) @(negedge clk);
    slow_clk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    rd(8'h04, rv); check("R9 ctrl", rv, 0);
    rd(8'h18, rv); check("R9 flags", rv, 0);
    rd(8'h20, rv); check("R9 cnt_lo", rv, 0);
    rd(8'h1C, rv); check("R9 cnt_hi", rv, 0);
    rd(8'h30, rv); check("R9 guard", rv, 0);
    check("R9 irq", {31'b0, irq}, 0);
    check("R9 wake", {31'b0, wake}, 0);
  endtask

  task automatic t_enable();
    wr(8'h04, 32'h1);
    rd(8'h04, rv); check("R3 run not yet applied", rv, 0);
    pulse();
    rd(8'h04, rv); check("R3 run applied", rv, 1);
    rd(8'h20, rv); check("R1 no step at enabling tick", rv, 0);
  endtask

  task automatic t_count();
    for (int i = 0; i < 3; i++) pulse();
    rd(8'h20, rv); check("R11 one step per pulse R1", rv, 3);
  endtask

  task automatic t_load_running();
    wr(8'h20, 32'h5 << 15);
    pulse();
    rd(8'h20, rv); check("R4 load ignored while running", rv, 4);
    wr(8'h04, 32'h0);
    pulse();
    rd(8'h20, rv); check("R4 stop tick still steps, load discarded", rv, 5);
  endtask

  task automatic t_load_stopped();
    logic [31:0] s;
    s = 32'hABCDE123;
    wr(8'h20, s << 15);
    wr(8'h1C, s >> 17);
    pulse();
    rd(8'h20, rv); check("R4 lo loaded R2", rv, s << 15);
    rd(8'h1C, rv); check("R4 hi loaded R2", rv, s >> 17);
    pulse();
    rd(8'h20, rv); check("R1 holds while stopped", rv, s << 15);
  endtask

  task automatic t_wrap();
    wr(8'h1C, 32'h7FFF);
    wr(8'h20, 32'hFFFF_FFFF);
    pulse();
    rd(8'h1C, rv); check("R2 hi all ones", rv, 32'h7FFF);
    wr(8'h04, 32'h1);
    pulse();
    pulse();
    rd(8'h20, rv); check("R1 wrap lo", rv, 0);
    rd(8'h1C, rv); check("R1 wrap hi", rv, 0);
    wr(8'h04, 32'h0);
    pulse();
  endtask

  task automatic t_alarm();
    wr(8'h20, 32'd10 << 15);
    wr(8'h1C, 32'h0);
    pulse();
    wr(8'h24, 32'd11);
    wr(8'h04, 32'hA);
    pulse();
    pulse();
    rd(8'h18, rv); check("R6 no match no flag", rv, 0);
    rd(8'h24, rv); check("R5 alarm readback", rv, 11);
    check("R7 irq idle", {31'b0, irq}, 0);
    wr(8'h24, 32'd10);
    pulse();
    rd(8'h18, rv); check("R5 alarm applied only at tick", rv, 0);
    pulse();
    rd(8'h18, rv); check("R6 flag set on match", rv, 1);
    check("R7 irq", {31'b0, irq}, 1);
    check("R7 wake", {31'b0, wake}, 1);
    wr(8'h18, 32'h1);
    rd(8'h18, rv); check("R6 w1c clears", rv, 0);
    check("R7 irq cleared", {31'b0, irq}, 0);
    pulse();
    rd(8'h18, rv); check("R6 re-set on match", rv, 1);
    wr(8'h18, 32'h0);
    rd(8'h18, rv); check("R6 write 0 keeps flag", rv, 1);
    wr(8'h04, 32'h2);
    pulse();
    check("R7 wake gated", {31'b0, wake}, 0);
    check("R7 irq with alarm only", {31'b0, irq}, 1);
    wr(8'h04, 32'h0);
    pulse();
    rd(8'h18, rv); check("R6 sticky after disable", rv, 1);
    check("R7 irq gated by alarm enable", {31'b0, irq}, 0);
    wr(8'h18, 32'h1);
    pulse();
    rd(8'h18, rv); check("R6 disabled alarm no set", rv, 0);
  endtask

  task automatic t_guard();
    wr(8'h30, 32'h41736166);
    rd(8'h30, rv); check("R8 guard word", rv, 32'h41736166);
    rd(8'h08, rv); check("R9 unmapped", rv, 0);
    rd(8'h20, rv); check("R10 read next cycle", rv, 32'd10 << 15);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_count();
    t_load_running();
    t_load_stopped();
    t_wrap();
    t_alarm();
    t_guard();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule